// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block decides when a DRAM channel gets an all-bank auto refresh and steps the channel through it. A countdown tracks the next due point. When that point arrives, the sequencer reads the controller's power state. If the channel is already idle with every bank precharged, the refresh command goes out on the next cycle. If it is not idle, the sequencer first issues a precharge request to each bank that still holds an open row. It waits until each such bank can legally be closed, and then waits out the row-precharge time of the last bank it closed.

While the sequence runs, the block raises a level that stops the controller from scheduling new requests. The refresh command then holds all banks busy for the refresh cycle time. When that time is over, a one-cycle completion pulse goes out and the blocking level drops in that same cycle, so request scheduling can resume at once. The interval to the next due point is measured from the refresh command, shortened by the precharge time, so that any close-out phase fits inside the refresh interval.

The controller owns the bank bookkeeping. It reports which banks have an open row and which banks have met their own timing (bank free and row-active time satisfied). It also clears a bank's open flag when it sees that bank's precharge request.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and right after it, `pre_req`, `ref_cmd`, `ref_done` and `block_req` are all 0.
- R2: Counting the first rising edge with `rst_n` high as edge 1, the first `ref_cmd` pulse is visible right after edge T_REFI−T_RP when `pwr_idle` is high, and `block_req` stays low before that.
- R3: If `pwr_idle` is high in the cycle the refresh falls due, no precharge request is issued, and `ref_cmd` pulses on the following cycle.
- R4: If `pwr_idle` is low when the refresh falls due, `block_req` rises in the next cycle. After that, `pre_req[b]` pulses for exactly one cycle, once, for each bank b whose `bank_open[b]` and `bank_ready[b]` were both 1 in the previous cycle. No pulse is issued for a bank whose `bank_open` is 0.
- R5: A bank with `bank_open` high and `bank_ready` low gets no precharge request until its `bank_ready` goes high. Its request then follows one cycle later.
- R6: After a close-out phase, `ref_cmd` pulses exactly T_RP+1 cycles after the last `pre_req` pulse, provided the controller drops each `bank_open` bit in the cycle its `pre_req` bit is seen.
- R7: `ref_cmd` is a single-cycle pulse, and `block_req` is high in every cycle from the one after the due point through the last cycle of the refresh.
- R8: `ref_done` pulses exactly T_RFC cycles after `ref_cmd`. In that same cycle `block_req` is low.
- R9: Consecutive `ref_cmd` pulses are T_REFI−T_RP cycles apart when the power state is idle at each due point.
- R10: `ref_cmd` is never issued while any `bank_open` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_open | input | NUM_BANKS | Bit b high: bank b holds an open row |
| bank_ready | input | NUM_BANKS | Bit b high: bank b is free and its row-active time is met, so it may be precharged |
| pwr_idle | input | 1 | Controller power state is idle (all banks precharged) |
| pre_req | output | NUM_BANKS | One-cycle precharge request per bank during close-out |
| ref_cmd | output | 1 | One-cycle all-bank refresh command |
| block_req | output | 1 | High while new request scheduling must be held off |
| ref_done | output | 1 | One-cycle pulse when the refresh cycle time has elapsed |

## Verification
The bench builds the block with four banks, T_REFI=40, T_RP=4 and T_RFC=6. With this short interval, six refreshes fit into about 250 cycles. That is enough for the skip path, a close-out with all banks ready, a close-out where one bank is held back by its timing, and the return to the skip path. The spacing between refreshes is measured in both directions. With four banks, open and closed banks can be mixed in one close-out, so the bench can confirm that closed banks never get a request.

// File: rtl/dram_ref_pkg.sv
// Package: shared types for the DRAM refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_ref_pkg;

    // Sequencer phases: waiting for the due point, closing banks, refreshing
    typedef enum logic [1:0] {
        SEQ_WAIT    = 2'd0,
        SEQ_CLOSE   = 2'd1,
        SEQ_REFRESH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
// Module: ref_interval_timer
// Counts down to the next refresh due point. It is reloaded when a refresh
// command is launched, so the spacing between commands is T_REFI - T_RP cycles.
// Assumes: T_REFI > T_RP + 1. The count saturates at zero until reloaded.
module ref_interval_timer #(
    parameter int T_REFI = 7800,
    parameter int T_RP   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic due
);
    localparam int GAP_W  = $clog2(T_REFI + 1);
    localparam int RELOAD = T_REFI - T_RP - 1;

    logic [GAP_W-1:0] gap_q;

    // Count down toward the due point; restart the interval on reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(RELOAD);
        end else if (reload) begin
            gap_q <= GAP_W'(RELOAD);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign due = (gap_q == '0);
endmodule

// File: rtl/ref_bank_closer.sv
// Module: ref_bank_closer
// Closes one bank during the close-out phase. It issues one precharge request
// once the bank is open and timing-ready, then reports busy for T_RP cycles.
// Assumes: T_RP >= 1. The controller clears bank_open after seeing pre_req.
module ref_bank_closer #(
    parameter int T_RP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic close_en,
    input  logic bank_open,
    input  logic bank_ready,
    output logic pre_req,
    output logic busy
);
    localparam int TMR_W = $clog2(T_RP + 1);

    logic             issued_q;
    logic [TMR_W-1:0] tmr_q;
    logic             fire;

    // A bank is closed once per close-out phase, when open and ready
    assign fire = close_en && bank_open && bank_ready && !issued_q;

    // Issue the request and run the precharge timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_req  <= 1'b0;
            issued_q <= 1'b0;
            tmr_q    <= '0;
        end else begin
            pre_req  <= fire;
            issued_q <= close_en && (issued_q || fire);
            if (fire) begin
                tmr_q <= TMR_W'(T_RP);
            end else if (tmr_q != '0) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end
    end

    assign busy = (tmr_q != '0);
endmodule

// File: rtl/dram_refresh_seq.sv
// Module: dram_refresh_seq (top)
// All-bank auto refresh sequencer. At each due point it either starts the
// refresh directly (power state idle) or first closes open banks and waits
// out tRP. It then holds the channel for tRFC while blocking new requests.
// Assumes: T_RFC >= 1, T_RP >= 1, T_REFI > T_RP + 1. The controller drops a
// bank_open bit once it sees the matching pre_req bit.
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_REFI    = 7800,
    parameter int T_RP      = 14,
    parameter int T_RFC     = 280
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic [NUM_BANKS-1:0] bank_ready,
    input  logic                 pwr_idle,
    output logic [NUM_BANKS-1:0] pre_req,
    output logic                 ref_cmd,
    output logic                 block_req,
    output logic                 ref_done
);
    localparam int RFC_W = $clog2(T_RFC + 1);

    seq_state_e           state_q;
    logic [RFC_W-1:0]     rfc_q;
    logic [NUM_BANKS-1:0] bank_busy;
    logic                 due;
    logic                 close_en;
    logic                 all_quiet;
    logic                 launch;

    assign close_en  = (state_q == SEQ_CLOSE);
    assign all_quiet = (bank_open == '0) && (bank_busy == '0);
    assign launch    = ((state_q == SEQ_WAIT) && due && pwr_idle) ||
                       ((state_q == SEQ_CLOSE) && all_quiet);

    ref_interval_timer #(
        .T_REFI (T_REFI),
        .T_RP   (T_RP)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (launch),
        .due    (due)
    );

    // One closer per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ref_bank_closer #(
            .T_RP (T_RP)
        ) u_closer (
            .clk        (clk),
            .rst_n      (rst_n),
            .close_en   (close_en),
            .bank_open  (bank_open[b]),
            .bank_ready (bank_ready[b]),
            .pre_req    (pre_req[b]),
            .busy       (bank_busy[b])
        );
    end

    // Phase sequencing, refresh command and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_WAIT;
            rfc_q    <= '0;
            ref_cmd  <= 1'b0;
            ref_done <= 1'b0;
        end else begin
            ref_cmd  <= launch;
            ref_done <= 1'b0;
            if (launch) begin
                state_q <= SEQ_REFRESH;
                rfc_q   <= RFC_W'(T_RFC - 1);
            end else begin
                unique case (state_q)
                    SEQ_WAIT: begin
                        if (due) state_q <= SEQ_CLOSE;
                    end
                    SEQ_CLOSE: begin
                        state_q <= SEQ_CLOSE;
                    end
                    SEQ_REFRESH: begin
                        if (rfc_q == '0) begin
                            state_q  <= SEQ_WAIT;
                            ref_done <= 1'b1;
                        end else begin
                            rfc_q <= rfc_q - 1'b1;
                        end
                    end
                    default: state_q <= SEQ_WAIT;
                endcase
            end
        end
    end

    assign block_req = (state_q != SEQ_WAIT);
endmodule

// File: rtl/dram_refresh_seq_chk.sv
// Module: dram_refresh_seq_chk
// Port-level properties of the refresh sequencer, bound to every instance.
// Assumes: the same parameters as the bound instance.
module dram_refresh_seq_chk #(
    parameter int NUM_BANKS = 8,
    parameter int T_RFC     = 280
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic [NUM_BANKS-1:0] pre_req,
    input logic                 ref_cmd,
    input logic                 block_req,
    input logic                 ref_done
);
    localparam int SC_W = $clog2(T_RFC + 2);

    logic [SC_W-1:0] since_cmd;

    // Cycles elapsed since the latest refresh command, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= '0;
        end else if (ref_cmd) begin
            since_cmd <= SC_W'(1);
        end else if (since_cmd != '0 && since_cmd != SC_W'(T_RFC + 1)) begin
            since_cmd <= since_cmd + 1'b1;
        end
    end

    p_pre_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pre_req) |-> ((pre_req & ~$past(bank_open & bank_ready)) == '0));

    p_pre_while_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pre_req) |-> (block_req && !ref_cmd));

    p_cmd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);

    p_cmd_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> block_req);

    p_done_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> (since_cmd == SC_W'(T_RFC)));

    p_done_unblocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> !block_req);

    p_cmd_no_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (bank_open == '0));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RFC     (T_RFC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_open  (bank_open),
    .bank_ready (bank_ready),
    .pre_req    (pre_req),
    .ref_cmd    (ref_cmd),
    .block_req  (block_req),
    .ref_done   (ref_done)
);

// File: tb/test_dram_refresh_seq.sv
// Scoreboard bench: the driver pushes expected events (cycle, kind, tag),
// the monitor pops and compares them as the outputs pulse.
module test_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int REFI   = 40;
    localparam int RP     = 4;
    localparam int RFC    = 6;
    localparam int K_CMD  = NB;
    localparam int K_DONE = NB + 1;

    typedef struct {
        int    cyc;
        int    kind;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic [NB-1:0] bank_ready = '1;
    logic          pwr_idle = 1'b1;
    logic [NB-1:0] pre_req;
    logic          ref_cmd;
    logic          block_req;
    logic          ref_done;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    dram_refresh_seq #(
        .NUM_BANKS (NB),
        .T_REFI    (REFI),
        .T_RP      (RP),
        .T_RFC     (RFC)
    ) i_dram_refresh_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_open  (bank_open),
        .bank_ready (bank_ready),
        .pwr_idle   (pwr_idle),
        .pre_req    (pre_req),
        .ref_cmd    (ref_cmd),
        .block_req  (block_req),
        .ref_done   (ref_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic expect_ev(input int c, input int k, input string r);
        exp_t e;
        e.cyc = c; e.kind = k; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic check_ev(input int k);
        exp_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: kind %0d at cycle %0d, expected none", k, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.cyc != cyc) begin
                n_bad++;
                $display("FAIL %s: got kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                         e.req, k, cyc, e.kind, e.cyc);
            end
        end
    endtask

    task automatic check_lvl(input string r, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %0h, expected %0h", r, cyc, act, exp_v);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    // Monitor and controller model: compare pulses, close banks on request
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            for (int b = 0; b < NB; b++) if (pre_req[b]) check_ev(b);
            if (ref_cmd) check_ev(K_CMD);
            if (ref_done) check_ev(K_DONE);
            if (|pre_req) bank_open = bank_open & ~pre_req;
        end
    end

    // Driver
    initial begin
        // Skip path: R2 first refresh, R3 skip, R9 spacing, R8 completion
        expect_ev(36, K_CMD, "R2");  expect_ev(42, K_DONE, "R8");
        expect_ev(72, K_CMD, "R3");  expect_ev(78, K_DONE, "R8");
        // Close-out with ready banks 0 and 2 (R4, R6)
        expect_ev(109, 0, "R4");     expect_ev(109, 2, "R4");
        expect_ev(114, K_CMD, "R6"); expect_ev(120, K_DONE, "R8");
        expect_ev(150, K_CMD, "R9"); expect_ev(156, K_DONE, "R8");
        // Close-out with bank 3 held back by timing (R5)
        expect_ev(187, 1, "R4");     expect_ev(191, 3, "R5");
        expect_ev(196, K_CMD, "R6"); expect_ev(202, K_DONE, "R8");
        expect_ev(232, K_CMD, "R9"); expect_ev(238, K_DONE, "R8");

        repeat (3) @(negedge clk);
        check_lvl("R1", {28'd0, pre_req}, 32'd0);
        check_lvl("R1", {29'd0, ref_cmd, ref_done, block_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_lvl("R1", {28'd0, pre_req}, 32'd0);
        check_lvl("R1", {29'd0, ref_cmd, ref_done, block_req}, 32'd0);

        wait_cyc(35);
        check_lvl("R2", {31'd0, block_req}, 32'd0);
        wait_cyc(37);
        check_lvl("R7", {31'd0, block_req}, 32'd1);

        wait_cyc(90);
        pwr_idle   = 1'b0;
        bank_open  = 4'b0101;
        bank_ready = 4'b1111;
        wait_cyc(107);
        check_lvl("R4", {31'd0, block_req}, 32'd0);
        wait_cyc(108);
        check_lvl("R4", {31'd0, block_req}, 32'd1);
        check_lvl("R4", {28'd0, pre_req}, 32'd0);
        wait_cyc(112);
        check_lvl("R7", {31'd0, block_req}, 32'd1);
        wait_cyc(119);
        check_lvl("R7", {31'd0, block_req}, 32'd1);
        wait_cyc(120);
        check_lvl("R8", {31'd0, block_req}, 32'd0);

        wait_cyc(125);
        pwr_idle = 1'b1;

        wait_cyc(160);
        pwr_idle   = 1'b0;
        bank_open  = 4'b1010;
        bank_ready = 4'b0010;
        wait_cyc(190);
        check_lvl("R5", {28'd0, pre_req}, 32'd0);
        check_lvl("R5", {31'd0, block_req}, 32'd1);
        bank_ready = 4'b1111;

        wait_cyc(205);
        pwr_idle = 1'b1;

        wait_cyc(245);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: %0d expected events never seen, expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 2000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end by 245", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule